// File: doc/BRIEF.md
# Register-Driven Indirect Serial Memory Controller

This block sits on a simple register bus and gives a host indirect access to byte-addressed serial memories. The memories hang off numbered ports. The host never addresses memory directly. It writes a command word into the control register, polls the status register, and moves data through the data register. An internal state machine allows only a fixed order of register accesses: set the address, then read; or begin a write, then supply its bytes. Any access that breaks this order traps the block in an error state, and only a write to the reset register brings it back.

The bit-level serial engine is not modelled. Each attached device is a small on-chip byte store, selected by its port number together with its device identifier. Every device keeps its own address pointer. That pointer advances by the number of bytes each data transfer moves. Each command occupies the block for a fixed number of cycles, which stands for bus time.

Top module: `ind_mem_ctl`

## Requirements
- R1: After reset the status word is zero, the block is idle, and no response is driven until a request arrives.
- R2: Every request cycle is answered exactly one cycle later by `bus_ack`. `bus_err` is set only for an access that is not allowed in the current state. Read data is zero for writes and for refused accesses.
- R3: Control word layout, from bit 63 down: start flag, with-address flag (62), continue flag, stop flag, length [59:56], device id [55:49], read flag (48), speed [47:46], port [45:41], address byte count [40:38], six reserved bits, then four address bytes [31:0]. A command with the with-address flag set, the read flag clear and length 0 loads the device pointer from the upper N bytes of [31:0], where N is the address byte count and must be 1 to 4. The command then keeps status bit 19 (busy) set for LAT cycles and afterwards sets bit 11 (complete).
- R4: A command with the with-address flag clear, the read flag set and length 1 to 8 reads that many bytes from the device pointer. After LAT cycles the block sets status bit 12 (data request) and puts the byte count in status [7:0]. A read of the data register then returns the bytes left-justified with zeros below them, clears bits 12 and [7:0], and sets bit 11.
- R5: The pointer of a device advances by the length of each of its data transfers and wraps modulo MEM_BYTES. Each device has its own pointer.
- R6: A command with the with-address flag set, the read flag clear and length 1 to 8 loads the pointer and sets bit 12. A following write to the data register supplies the bytes, left-justified. The bytes are stored LAT cycles after that write, and then bit 11 is set.
- R7: A device is selected by its (port, id) pair. A legal command that names no attached pair sets status bit 13 (no acknowledge), leaves every pointer unchanged, stays idle, and is answered without error.
- R8: Register offsets are control 0, reset 1, status 2, data 3. Reading the status register and writing the reset register are always allowed. Reading the control register is allowed except in the error state. Writing the control register is allowed only when idle. The data register may be read only when data is available, and written only while the block waits for write bytes. Any other access sets bit 18 (invalid command) and enters the error state. In that state every access except a status read or a reset write is refused.
- R9: A write to the reset register, in any state, returns the block to idle, clears the status and the read buffer, and cancels any transfer in progress. Memory contents and device pointers are kept.
- R10: The speed field (0 to 3) and the start, continue and stop flags have no effect on behaviour.
- R11: After a hard reset, the byte at offset a of device d holds (a + 16*d) mod 256.
- R12: The following control words are invalid commands under R8: length above 8, an address byte count of 0 or above 4 on a command that carries an address, a read with the with-address flag set, and a read of length 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 64 | Write data |
| bus_ack | output | 1 | Response strobe, one cycle after the request |
| bus_err | output | 1 | Access refused |
| bus_rdata | output | 64 | Read data of the answered access |

## Verification
Most internal faults reach the ports within one access. A wrong state shows up as an error response to a legal access, or as a missing error on an illegal one, at the very next request. A wrong pointer or a wrong byte order shows up in the data-register word after the following read command. That is at most LAT plus two cycles after the command. A fault in the busy counter shifts the moment when status bits 19, 12 and 11 change, and a status poll during the busy window catches this. A compare on every clock against a behavioural model catches each of these faults at the first response where it differs.

// File: rtl/ind_mem_ctl.sv
module ind_mem_ctl #(
  parameter int NUM_DEV = 2,
  parameter int MEM_BYTES = 256,
  parameter int LAT = 4,
  parameter logic [NUM_DEV*5-1:0] DEV_PORTS = {5'd3, 5'd0},
  parameter logic [NUM_DEV*7-1:0] DEV_IDS = {7'h51, 7'h50}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [63:0] bus_wdata,
  output logic        bus_ack,
  output logic        bus_err,
  output logic [63:0] bus_rdata
);
  localparam int PW = $clog2(MEM_BYTES);
  localparam int DW = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int CW = $clog2(LAT + 1);
  localparam int NB = NUM_DEV * MEM_BYTES;

  typedef enum logic [2:0] {S_TRAP, S_IDLE, S_AWR, S_RD, S_AVAIL, S_WEXP, S_WR} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [63:0] ctrl_q, fifo, wbuf, rd_word, stat, rmux;
  logic [7:0] fcnt;
  logic [3:0] len_q;
  logic [DW-1:0] dev_q, hidx;
  logic f_inv, f_nack, f_dreq, f_done, hit, legal, bad, kill, fin, busy;
  logic [PW-1:0] ptr [NUM_DEV];
  logic [7:0] mem [NB];

  wire rst_w = bus_req & bus_wr & (bus_addr == 2'd1);
  wire ctl_w = bus_req & bus_wr & (bus_addr == 2'd0);
  wire dat_r = bus_req & ~bus_wr & (bus_addr == 2'd3);
  wire dat_w = bus_req & bus_wr & (bus_addr == 2'd3);

  wire       c_wa   = bus_wdata[62];
  wire [3:0] c_len  = bus_wdata[59:56];
  wire [6:0] c_id   = bus_wdata[55:49];
  wire       c_rnw  = bus_wdata[48];
  wire [4:0] c_port = bus_wdata[45:41];
  wire [2:0] c_ar   = bus_wdata[40:38];
  wire ar_ok  = (c_ar != 3'd0) && (c_ar <= 3'd4);
  wire len_ok = (c_len != 4'd0) && (c_len <= 4'd8);
  wire is_aw  = c_wa & ~c_rnw & (c_len == 4'd0) & ar_ok;
  wire is_dw  = c_wa & ~c_rnw & len_ok & ar_ok;
  wire is_dr  = ~c_wa & c_rnw & len_ok;
  wire [5:0]  sh     = {3'd4 - c_ar, 3'b000};
  wire [31:0] c_addr = bus_wdata[31:0] >> sh;

  assign busy = (st == S_AWR) || (st == S_RD) || (st == S_WR);

  always_comb begin
    hit = 1'b0;
    hidx = '0;
    for (int i = 0; i < NUM_DEV; i++)
      if (!hit && DEV_PORTS[i*5 +: 5] == c_port && DEV_IDS[i*7 +: 7] == c_id) begin
        hit = 1'b1;
        hidx = DW'(i);
      end
  end

  always_comb begin
    case ({bus_wr, bus_addr})
      3'b101:  legal = 1'b1;
      3'b010:  legal = 1'b1;
      3'b000:  legal = (st != S_TRAP);
      3'b100:  legal = (st == S_IDLE) && (is_aw || is_dw || is_dr);
      3'b011:  legal = (st == S_AVAIL);
      3'b111:  legal = (st == S_WEXP);
      default: legal = 1'b0;
    endcase
  end

  assign bad  = bus_req & ~legal;
  assign kill = bus_req & (bad | rst_w);
  assign fin  = busy & (cnt == '0) & ~kill;

  assign stat = {44'd0, busy, f_inv, 4'd0, f_nack, f_dreq, f_done, 3'd0, fcnt};

  always_comb begin
    case (bus_addr)
      2'd0:    rmux = ctrl_q;
      2'd2:    rmux = stat;
      2'd3:    rmux = fifo;
      default: rmux = '0;
    endcase
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < 8; k++)
      if (4'(k) < len_q)
        rd_word[63-8*k -: 8] = mem[int'(dev_q)*MEM_BYTES + int'(PW'(ptr[dev_q] + PW'(k)))];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack <= 1'b0;
      bus_err <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= bus_req;
      bus_err <= bad;
      bus_rdata <= (bus_req && legal && !bus_wr) ? rmux : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      ctrl_q <= '0;
      fifo <= '0;
      wbuf <= '0;
      fcnt <= '0;
      len_q <= '0;
      dev_q <= '0;
      f_inv <= 1'b0;
      f_nack <= 1'b0;
      f_dreq <= 1'b0;
      f_done <= 1'b0;
      for (int i = 0; i < NUM_DEV; i++) ptr[i] <= '0;
    end else if (bad) begin
      st <= S_TRAP;
      f_inv <= 1'b1;
    end else if (rst_w) begin
      st <= S_IDLE;
      cnt <= '0;
      fifo <= '0;
      fcnt <= '0;
      f_inv <= 1'b0;
      f_nack <= 1'b0;
      f_dreq <= 1'b0;
      f_done <= 1'b0;
    end else begin
      if (busy && !fin) cnt <= cnt - 1'b1;
      if (fin) begin
        case (st)
          S_RD: begin
            fifo <= rd_word;
            fcnt <= 8'(len_q);
            f_dreq <= 1'b1;
            st <= S_AVAIL;
            ptr[dev_q] <= ptr[dev_q] + PW'(len_q);
          end
          S_WR: begin
            f_done <= 1'b1;
            st <= S_IDLE;
            ptr[dev_q] <= ptr[dev_q] + PW'(len_q);
          end
          default: begin
            f_done <= 1'b1;
            st <= S_IDLE;
          end
        endcase
      end
      if (ctl_w) begin
        ctrl_q <= bus_wdata;
        f_done <= 1'b0;
        f_nack <= ~hit;
        if (hit) begin
          dev_q <= hidx;
          len_q <= c_len;
          cnt <= CW'(LAT - 1);
          if (is_dr) st <= S_RD;
          else begin
            ptr[hidx] <= c_addr[PW-1:0];
            if (is_aw) st <= S_AWR;
            else begin
              st <= S_WEXP;
              f_dreq <= 1'b1;
            end
          end
        end
      end
      if (dat_r) begin
        st <= S_IDLE;
        fifo <= '0;
        fcnt <= '0;
        f_dreq <= 1'b0;
        f_done <= 1'b1;
      end
      if (dat_w) begin
        wbuf <= bus_wdata;
        f_dreq <= 1'b0;
        cnt <= CW'(LAT - 1);
        st <= S_WR;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem[i] <= 8'((i % MEM_BYTES) + 16 * (i / MEM_BYTES));
    end else if (fin && st == S_WR) begin
      for (int k = 0; k < 8; k++)
        if (4'(k) < len_q)
          mem[int'(dev_q)*MEM_BYTES + int'(PW'(ptr[dev_q] + PW'(k)))] <= wbuf[63-8*k -: 8];
    end
  end

  assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |=> bus_ack);
  assert_err_sets_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && bus_err) |-> f_inv);
  assert_trap_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TRAP && !rst_w) |=> (st == S_TRAP));
  assert_busy_ends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == '0 && !kill) |=> !busy);
  assert_fifo_only_avail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fcnt != 8'd0) |-> (st == S_AVAIL));
  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_done, f_dreq, busy}));
endmodule

// File: tb/ind_mem_ctl_tb.sv
`timescale 1ns/1ps
module ind_mem_ctl_tb;
  localparam int LAT = 4;
  logic clk = 0, rst_n = 0;
  logic req = 0, wr = 0;
  logic [1:0] ad = 0;
  logic [63:0] wd = 0;
  logic bus_ack, bus_err;
  logic [63:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  string phase = "R1";
  logic r_ack, r_err;
  logic [63:0] r_data;

  localparam logic [63:0] BSY = 64'h1 << 19, INV = 64'h1 << 18, NAK = 64'h1 << 13,
                          DRQ = 64'h1 << 12, DON = 64'h1 << 11;

  always #2.5 clk = ~clk;

  ind_mem_ctl #(.LAT(LAT)) u_dut (.clk(clk), .rst_n(rst_n), .bus_req(req), .bus_wr(wr),
    .bus_addr(ad), .bus_wdata(wd), .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata));

  // behavioural reference
  int m_st, m_cnt, m_fcnt, m_len, m_dev;
  logic [63:0] m_ctrl, m_fifo, m_wbuf;
  bit m_inv, m_nack, m_dreq, m_done;
  int m_ptr [2];
  int m_mem [2][256];
  logic e_ack, e_err;
  logic [63:0] e_rd;

  function automatic int find_dev(input int port, input int id);
    if (port == 0 && id == 'h50) return 0;
    if (port == 3 && id == 'h51) return 1;
    return -1;
  endfunction

  function automatic bit cmd_ok(input logic [63:0] w);
    int len, ar;
    len = int'(w[59:56]);
    ar = int'(w[40:38]);
    if (w[62] && !w[48]) return (len <= 8) && (ar >= 1) && (ar <= 4);
    if (!w[62] && w[48]) return (len >= 1) && (len <= 8);
    return 0;
  endfunction

  function automatic logic [63:0] m_status();
    logic [63:0] s;
    s = 0;
    s[19] = (m_st == 2 || m_st == 3 || m_st == 6);
    s[18] = m_inv;
    s[13] = m_nack;
    s[12] = m_dreq;
    s[11] = m_done;
    s[7:0] = 8'(m_fcnt);
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 1; m_cnt = 0; m_fcnt = 0; m_len = 0; m_dev = 0;
      m_ctrl = 0; m_fifo = 0; m_wbuf = 0;
      m_inv = 0; m_nack = 0; m_dreq = 0; m_done = 0;
      for (int d = 0; d < 2; d++) begin
        m_ptr[d] = 0;
        for (int a = 0; a < 256; a++) m_mem[d][a] = (a + 16 * d) % 256;
      end
      e_ack = 0; e_err = 0; e_rd = 0;
    end else begin
      bit ok;
      ok = 0;
      if (req) begin
        if (wr && ad == 1) ok = 1;
        else if (!wr && ad == 2) ok = 1;
        else if (m_st == 0) ok = 0;
        else if (!wr && ad == 0) ok = 1;
        else if (wr && ad == 0) ok = (m_st == 1) && cmd_ok(wd);
        else if (!wr && ad == 3) ok = (m_st == 4);
        else if (wr && ad == 3) ok = (m_st == 5);
      end
      e_ack = req;
      e_err = req && !ok;
      e_rd = 0;
      if (req && ok && !wr) e_rd = (ad == 0) ? m_ctrl : (ad == 2) ? m_status() : (ad == 3) ? m_fifo : 0;
      if (req && !ok) begin
        m_st = 0; m_inv = 1;
      end else if (req && wr && ad == 1) begin
        m_st = 1; m_cnt = 0; m_fifo = 0; m_fcnt = 0;
        m_inv = 0; m_nack = 0; m_dreq = 0; m_done = 0;
      end else begin
        if (m_st == 2 || m_st == 3 || m_st == 6) begin
          if (m_cnt > 0) m_cnt--;
          else if (m_st == 3) begin
            m_fifo = 0;
            for (int k = 0; k < m_len; k++)
              m_fifo |= 64'(m_mem[m_dev][(m_ptr[m_dev] + k) % 256]) << (56 - 8 * k);
            m_ptr[m_dev] = (m_ptr[m_dev] + m_len) % 256;
            m_fcnt = m_len; m_dreq = 1; m_st = 4;
          end else begin
            if (m_st == 6) begin
              for (int k = 0; k < m_len; k++)
                m_mem[m_dev][(m_ptr[m_dev] + k) % 256] = int'((m_wbuf >> (56 - 8 * k)) & 64'hFF);
              m_ptr[m_dev] = (m_ptr[m_dev] + m_len) % 256;
            end
            m_done = 1; m_st = 1;
          end
        end
        if (req && wr && ad == 0) begin
          int dv;
          m_ctrl = wd;
          m_done = 0;
          dv = find_dev(int'(wd[45:41]), int'(wd[55:49]));
          m_nack = (dv < 0);
          if (dv >= 0) begin
            m_dev = dv;
            m_len = int'(wd[59:56]);
            m_cnt = LAT - 1;
            if (wd[48]) m_st = 3;
            else begin
              m_ptr[dv] = int'(wd[31:0] >> (8 * (4 - int'(wd[40:38])))) % 256;
              if (m_len == 0) m_st = 2;
              else begin m_st = 5; m_dreq = 1; end
            end
          end
        end
        if (req && !wr && ad == 3) begin
          m_st = 1; m_fifo = 0; m_fcnt = 0; m_dreq = 0; m_done = 1;
        end
        if (req && wr && ad == 3) begin
          m_wbuf = wd; m_dreq = 0; m_cnt = LAT - 1; m_st = 6;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (bus_ack !== e_ack || bus_err !== e_err || bus_rdata !== e_rd) begin
        n_bad++;
        $display("FAIL %s cycle compare: act ack=%b err=%b rd=%h exp ack=%b err=%b rd=%h",
                 phase, bus_ack, bus_err, bus_rdata, e_ack, e_err, e_rd);
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; wr = w; ad = a; wd = d;
    @(negedge clk);
    r_ack = bus_ack; r_err = bus_err; r_data = bus_rdata;
    req = 0; wr = 0; wd = 0;
  endtask

  task automatic wt();
    repeat (LAT + 1) @(negedge clk);
  endtask

  function automatic logic [63:0] ctl(input logic wa, input logic rnw, input logic [3:0] len,
      input logic [6:0] id, input logic [4:0] port, input logic [2:0] ar,
      input logic [1:0] spd, input logic [2:0] fl, input logic [31:0] low);
    return {fl[2], wa, fl[1], fl[0], len, id, rnw, spd, port, ar, 6'd0, low};
  endfunction

  task automatic st_is(input string tag, input logic [63:0] exp);
    acc(0, 2, 0);
    chk(tag, r_data, exp);
  endtask

  task automatic data_is(input string tag, input logic [63:0] exp);
    acc(0, 3, 0);
    chk(tag, {r_err, r_data}, {1'b0, exp});
  endtask

  task automatic soft_rst();
    acc(1, 1, 0);
    chk("R9 reset write accepted", {r_ack, r_err}, 2'b10);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog expired in %s act=running exp=finished", phase);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    st_is("R1 status after reset", 0);
    chk("R1 R2 ack without error", {r_ack, r_err}, 2'b10);

    phase = "R3";
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 2, 0, 0, 32'h0010_0000));
    chk("R2 address command accepted", r_err, 0);
    st_is("R3 busy during address write", BSY);
    wt();
    st_is("R3 complete after address write", DON);

    phase = "R4";
    acc(1, 0, ctl(0, 1, 4, 7'h50, 0, 0, 0, 0, 0));
    wt();
    st_is("R4 data request and count", DRQ | 64'd4);
    data_is("R4 R11 read bytes left-justified", 64'h1011_1213_0000_0000);
    st_is("R4 complete after data read", DON);

    phase = "R5";
    acc(1, 0, ctl(0, 1, 3, 7'h50, 0, 0, 0, 0, 0));
    wt();
    data_is("R5 pointer advanced", 64'h1415_1600_0000_0000);
    acc(1, 0, ctl(1, 0, 0, 7'h51, 3, 1, 0, 0, 32'hFE00_0000));
    wt();
    acc(1, 0, ctl(0, 1, 4, 7'h51, 3, 0, 0, 0, 0));
    wt();
    data_is("R5 R11 pointer wraps on device 1", 64'h0E0F_1011_0000_0000);

    phase = "R6";
    acc(1, 0, ctl(1, 0, 3, 7'h51, 3, 4, 0, 0, 32'h0000_0020));
    st_is("R6 write waits for bytes", DRQ);
    acc(1, 3, 64'hA1B2_C3DD_EEFF_0011);
    chk("R6 data write accepted", r_err, 0);
    wt();
    st_is("R6 complete after write", DON);
    acc(1, 0, ctl(1, 0, 0, 7'h51, 3, 4, 0, 0, 32'h0000_0020));
    wt();
    acc(1, 0, ctl(0, 1, 5, 7'h51, 3, 0, 0, 0, 0));
    wt();
    data_is("R6 written bytes read back", 64'hA1B2_C333_3400_0000);

    phase = "R10";
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 2, 3, 3'b111, 32'h0010_0000));
    wt();
    acc(1, 0, ctl(0, 1, 1, 7'h50, 0, 0, 2, 3'b101, 0));
    wt();
    data_is("R10 speed and flags ignored", 64'h1000_0000_0000_0000);

    phase = "R7";
    acc(1, 0, ctl(0, 1, 1, 7'h51, 0, 0, 0, 0, 0));
    chk("R7 unknown pair no error", r_err, 0);
    st_is("R7 no acknowledge flag", NAK);
    acc(1, 0, ctl(1, 0, 0, 7'h50, 3, 1, 0, 0, 32'h8000_0000));
    st_is("R7 swapped pair no acknowledge", NAK);
    acc(1, 0, ctl(0, 1, 1, 7'h50, 0, 0, 1, 0, 0));
    wt();
    data_is("R7 pointer unchanged by nack", 64'h1100_0000_0000_0000);

    phase = "R12";
    soft_rst();
    acc(1, 0, ctl(0, 1, 9, 7'h50, 0, 0, 0, 0, 0));
    chk("R12 length 9 refused", r_err, 1);
    st_is("R12 R8 invalid flag", INV);
    phase = "R8";
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 1, 0, 0, 0));
    chk("R8 valid command refused in error state", r_err, 1);
    acc(0, 0, 0);
    chk("R8 control read refused in error state", r_err, 1);
    soft_rst();
    st_is("R9 status cleared", 0);
    phase = "R12";
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 0, 0, 0, 0));
    chk("R12 zero address bytes refused", r_err, 1);
    soft_rst();
    acc(1, 0, ctl(1, 1, 2, 7'h50, 0, 1, 0, 0, 0));
    chk("R12 read with address refused", r_err, 1);
    soft_rst();
    acc(1, 0, ctl(0, 1, 0, 7'h50, 0, 0, 0, 0, 0));
    chk("R12 read length 0 refused", r_err, 1);
    soft_rst();

    phase = "R8";
    acc(0, 3, 0);
    chk("R8 data read when idle refused", r_err, 1);
    soft_rst();
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 1, 0, 0, 0));
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 1, 0, 0, 0));
    chk("R8 command while busy refused", r_err, 1);
    soft_rst();
    acc(1, 3, 0);
    chk("R8 data write when idle refused", r_err, 1);
    soft_rst();
    acc(0, 1, 0);
    chk("R8 reset register read refused", r_err, 1);
    acc(1, 2, 0);
    chk("R8 status write refused", r_err, 1);
    soft_rst();
    acc(0, 0, 0);
    chk("R8 control read allowed", r_err, 0);

    phase = "R9";
    acc(1, 0, ctl(0, 1, 2, 7'h50, 0, 0, 0, 0, 0));
    wt();
    soft_rst();
    st_is("R9 read buffer and flags cleared", 0);
    acc(0, 3, 0);
    chk("R9 no data after reset", r_err, 1);
    soft_rst();
    acc(1, 0, ctl(1, 0, 2, 7'h50, 0, 1, 0, 0, 32'h4000_0000));
    acc(1, 3, 64'hBEEF_0000_0000_0000);
    soft_rst();
    acc(1, 0, ctl(1, 0, 0, 7'h50, 0, 1, 0, 0, 32'h4000_0000));
    wt();
    acc(1, 0, ctl(0, 1, 2, 7'h50, 0, 0, 0, 0, 0));
    wt();
    data_is("R9 cancelled write left memory intact", 64'h4041_0000_0000_0000);

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule